// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block collects run-time statistics for a processor. It has one cycle counter and six programmable event counters, each 32 bits wide. Each event counter watches one of 256 event lines, chosen by an 8-bit code held per counter. Event code 0x00 is reserved for increments that software requests.

Software reaches the unit over a simple register bus. The bus has a write strobe, a read strobe, a word address, write data and a privilege flag. Read data and the error flag are combinational responses to the strobe in the same cycle. The event counters are not individually addressed: one select register steers the event-type and event-count windows to a single counter. Counter enables and interrupt enables are each set and cleared through separate write-one registers. A single interrupt output is raised while any flagged overflow is also interrupt-enabled.

Top module: `perf_mon_unit`

## Requirements
- R1: The register word offsets are: 0 control, 1 counter select, 2 event type, 3 event count, 4 cycle count, 5 enable-set, 6 enable-clear, 7 irq-enable-set, 8 irq-enable-clear, 9 overflow flags, 10 software increment, 11 user access. While control bit 0 (global run) is 0, no counter advances, whatever its own enable is.
- R2: Writing control with bit 1 set zeroes all event counters. Writing control with bit 2 set zeroes the cycle counter and its prescaler. Both bits always read back as 0.
- R3: While control bit 3 is 1, the cycle counter advances once per 64 enabled clock cycles. While it is 0, the cycle counter advances on every enabled cycle.
- R4: Control bits 15:11 read as the number of event counters (6) and ignore writes. Bits 0 and 3 read back as last written. All other control bits read 0.
- R5: The select register stores a 5-bit counter number. The event-type and event-count windows act on that counter only. A number of 6 or more reads those windows as 0 and drops writes to them.
- R6: An event counter with a nonzero code c advances by one on each clock edge where event line c is high, its enable is set and global run is set.
- R7: The enable set/clear registers use bit x for event counter x and bit 31 for the cycle counter. Writing 1 sets (or clears) the bit, and writing 0 leaves it unchanged. Unimplemented bits stay 0. Either offset reads back the current mask.
- R8: A counter that advances from all ones to zero sets its overflow flag. The flags use the R7 layout. Writing 1 to a flag bit clears it, but a wrap in the same cycle wins and leaves the flag set.
- R9: The interrupt output is high exactly while some overflow flag and its interrupt-enable bit are both set. The interrupt-enable bits use the R7 layout.
- R10: Writing 1 to bit x of the software increment register advances event counter x by one, but only if its code is 0x00, its enable is set and global run is set. Otherwise the write has no effect.
- R11: While user-access bit 0 is 0, an access with the privilege flag low raises the error flag, returns 0 and changes nothing. Once the bit is 1, such accesses behave normally with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| event_in | input | 256 | Event lines, one per event code |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | Access is privileged |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| bus_err | output | 1 | Access refused for lack of privilege |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The bench targets the cases where one control path could quietly override another.

- **Global run gating:** events keep toggling after global run drops. A design that let per-counter enables bypass it would keep counting.
- **Prescaler boundary:** the cycle counter is checked after exactly 128 enabled cycles. An off-by-one prescaler would read 1 or 3 instead of 2.
- **Software increment gating:** increments are requested on a counter with a nonzero code and while global run is off. A design that gated loosely would bump the count.
- **Select window:** an out-of-range select must not alias onto a real counter.
- **Overflow interrupt:** a wrap with the interrupt disabled must still set the flag but must not raise the interrupt.
- **Privilege:** an unprivileged write is refused. A design that only flagged the error would still change the select register.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;

    localparam int PM_NUM_CNT = 6;
    localparam int PM_CNT_W   = 32;
    localparam int PM_EVT_W   = 8;
    localparam int PM_PRESC_W = 6;
    localparam int PM_ADDR_W  = 4;
    localparam int PM_DATA_W  = 32;
    localparam int PM_SEL_W   = 5;
    localparam int PM_CYC_BIT = 31;

    typedef enum logic [PM_ADDR_W-1:0] {
        REG_CTRL    = 4'd0,
        REG_SEL     = 4'd1,
        REG_EVTYPE  = 4'd2,
        REG_EVCNT   = 4'd3,
        REG_CYCCNT  = 4'd4,
        REG_CEN_SET = 4'd5,
        REG_CEN_CLR = 4'd6,
        REG_IEN_SET = 4'd7,
        REG_IEN_CLR = 4'd8,
        REG_OVF     = 4'd9,
        REG_SWINC   = 4'd10,
        REG_USREN   = 4'd11
    } pm_reg_e;

    // Run state kept from the control register.
    typedef struct packed {
        logic run;
        logic div64;
    } pm_ctrl_t;

    // One-cycle commands decoded from a control write.
    typedef struct packed {
        logic clr_evt;
        logic clr_cyc;
    } pm_clr_t;

    // Mask of implemented bits in the enable/flag layout.
    function automatic logic [PM_DATA_W-1:0] pm_impl_mask(input int num_cnt);
        logic [PM_DATA_W-1:0] m;
        m = '0;
        for (int k = 0; k < num_cnt; k++) m[k] = 1'b1;
        m[PM_CYC_BIT] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/pm_event_counter.sv
module pm_event_counter
    import perf_mon_pkg::*;
#(
    parameter int CNT_W = PM_CNT_W,
    parameter int EVT_W = PM_EVT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [2**EVT_W-1:0] event_in,
    input  logic               code_wr,
    input  logic [EVT_W-1:0]   code_din,
    input  logic               sw_pulse,
    input  logic               clear,
    input  logic               load,
    input  logic [CNT_W-1:0]   load_val,
    output logic [CNT_W-1:0]   count,
    output logic [EVT_W-1:0]   code,
    output logic               wrap
);
    logic [CNT_W-1:0] count_q;
    logic [EVT_W-1:0] code_q;
    logic             hit;
    logic             inc;

    // Code zero selects the software source instead of an event line.
    assign hit  = (code_q == '0) ? sw_pulse : event_in[code_q];
    assign inc  = run && hit;
    assign wrap = inc && !clear && !load && (&count_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            code_q  <= '0;
        end else begin
            if (code_wr) code_q <= code_din;
            if (clear)     count_q <= '0;
            else if (load) count_q <= load_val;
            else if (inc)  count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;
    assign code  = code_q;
endmodule

// File: rtl/pm_cycle_counter.sv
module pm_cycle_counter
    import perf_mon_pkg::*;
#(
    parameter int CNT_W   = PM_CNT_W,
    parameter int PRESC_W = PM_PRESC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             div,
    input  logic             clear,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             step,
    output logic             wrap
);
    logic [CNT_W-1:0]   count_q;
    logic [PRESC_W-1:0] presc_q;

    assign step = run && (!div || (&presc_q));
    assign wrap = step && !clear && !load && (&count_q);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            presc_q <= '0;
        end else if (run) begin
            presc_q <= presc_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) count_q <= '0;
        else if (load)    count_q <= load_val;
        else if (step)    count_q <= count_q + 1'b1;
    end

    assign count = count_q;
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
    import perf_mon_pkg::*;
#(
    parameter int NUM_CNT = PM_NUM_CNT,
    parameter int CNT_W   = PM_CNT_W,
    parameter int EVT_W   = PM_EVT_W,
    parameter int PRESC_W = PM_PRESC_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2**EVT_W-1:0]  event_in,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [PM_ADDR_W-1:0] bus_addr,
    input  logic [PM_DATA_W-1:0] bus_wdata,
    input  logic                 bus_priv,
    output logic [PM_DATA_W-1:0] bus_rdata,
    output logic                 bus_err,
    output logic                 irq_o
);
    localparam logic [PM_DATA_W-1:0] IMPL = pm_impl_mask(NUM_CNT);

    pm_ctrl_t              ctrl_q;
    pm_clr_t               clr;
    logic [PM_SEL_W-1:0]   sel_q;
    logic [PM_DATA_W-1:0]  cen_q, ien_q, ovf_q;
    logic                  usr_en_q;

    logic                  blocked, wr_fire, rd_ok;
    logic [PM_DATA_W-1:0]  wmask;
    logic [NUM_CNT-1:0]    sw_vec, evt_wrap;
    logic [CNT_W-1:0]      evt_cnt  [NUM_CNT];
    logic [EVT_W-1:0]      evt_code [NUM_CNT];
    logic [CNT_W-1:0]      cyc_cnt;
    logic                  cyc_step, cyc_wrap;
    logic [PM_DATA_W-1:0]  wrap_vec;
    logic [CNT_W-1:0]      sel_cnt;
    logic [EVT_W-1:0]      sel_code;

    // Access qualification
    assign blocked = !bus_priv && !usr_en_q;
    assign bus_err = (bus_wr || bus_rd) && blocked;
    assign wr_fire = bus_wr && !blocked;
    assign rd_ok   = bus_rd && !blocked;
    assign wmask   = bus_wdata & IMPL;

    assign clr.clr_evt = wr_fire && (bus_addr == REG_CTRL) && bus_wdata[1];
    assign clr.clr_cyc = wr_fire && (bus_addr == REG_CTRL) && bus_wdata[2];
    assign sw_vec = (wr_fire && bus_addr == REG_SWINC) ? bus_wdata[NUM_CNT-1:0] : '0;

    // Wrap events, laid out like the enable registers
    always_comb begin
        wrap_vec = '0;
        wrap_vec[NUM_CNT-1:0] = evt_wrap;
        wrap_vec[PM_CYC_BIT]  = cyc_wrap;
    end

    // Register state
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            sel_q    <= '0;
            cen_q    <= '0;
            ien_q    <= '0;
            ovf_q    <= '0;
            usr_en_q <= 1'b0;
        end else begin
            if (wr_fire) begin
                unique case (bus_addr)
                    REG_CTRL: begin
                        ctrl_q.run   <= bus_wdata[0];
                        ctrl_q.div64 <= bus_wdata[3];
                    end
                    REG_SEL:     sel_q    <= bus_wdata[PM_SEL_W-1:0];
                    REG_CEN_SET: cen_q    <= cen_q | wmask;
                    REG_CEN_CLR: cen_q    <= cen_q & ~wmask;
                    REG_IEN_SET: ien_q    <= ien_q | wmask;
                    REG_IEN_CLR: ien_q    <= ien_q & ~wmask;
                    REG_USREN:   usr_en_q <= bus_wdata[0];
                    default: ;
                endcase
            end
            // A wrap in the same cycle outranks the clear request.
            ovf_q <= (ovf_q & ~((wr_fire && bus_addr == REG_OVF) ? wmask : '0)) | wrap_vec;
        end
    end

    // Event counters
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_evt
        logic picked;
        assign picked = (sel_q == PM_SEL_W'(i));

        pm_event_counter #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .run      (ctrl_q.run && cen_q[i]),
            .event_in (event_in),
            .code_wr  (wr_fire && bus_addr == REG_EVTYPE && picked),
            .code_din (bus_wdata[EVT_W-1:0]),
            .sw_pulse (sw_vec[i]),
            .clear    (clr.clr_evt),
            .load     (wr_fire && bus_addr == REG_EVCNT && picked),
            .load_val (bus_wdata[CNT_W-1:0]),
            .count    (evt_cnt[i]),
            .code     (evt_code[i]),
            .wrap     (evt_wrap[i])
        );
    end

    pm_cycle_counter #(.CNT_W(CNT_W), .PRESC_W(PRESC_W)) u_cyc (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl_q.run && cen_q[PM_CYC_BIT]),
        .div      (ctrl_q.div64),
        .clear    (clr.clr_cyc),
        .load     (wr_fire && bus_addr == REG_CYCCNT),
        .load_val (bus_wdata[CNT_W-1:0]),
        .count    (cyc_cnt),
        .step     (cyc_step),
        .wrap     (cyc_wrap)
    );

    // Indirect window: out-of-range selects match no counter and read 0.
    always_comb begin
        sel_cnt  = '0;
        sel_code = '0;
        for (int k = 0; k < NUM_CNT; k++) begin
            if (sel_q == PM_SEL_W'(k)) begin
                sel_cnt  = evt_cnt[k];
                sel_code = evt_code[k];
            end
        end
    end

    // Read data
    always_comb begin
        bus_rdata = '0;
        if (rd_ok) begin
            unique case (bus_addr)
                REG_CTRL: begin
                    bus_rdata[15:11] = 5'(NUM_CNT);
                    bus_rdata[3]     = ctrl_q.div64;
                    bus_rdata[0]     = ctrl_q.run;
                end
                REG_SEL:     bus_rdata = PM_DATA_W'(sel_q);
                REG_EVTYPE:  bus_rdata = PM_DATA_W'(sel_code);
                REG_EVCNT:   bus_rdata = PM_DATA_W'(sel_cnt);
                REG_CYCCNT:  bus_rdata = PM_DATA_W'(cyc_cnt);
                REG_CEN_SET,
                REG_CEN_CLR: bus_rdata = cen_q;
                REG_IEN_SET,
                REG_IEN_CLR: bus_rdata = ien_q;
                REG_OVF:     bus_rdata = ovf_q;
                REG_USREN:   bus_rdata = PM_DATA_W'(usr_en_q);
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign irq_o = |(ovf_q & ien_q);
endmodule

// File: rtl/perf_mon_checker.sv
module perf_mon_checker
    import perf_mon_pkg::*;
#(
    parameter int NUM_CNT = PM_NUM_CNT,
    parameter int CNT_W   = PM_CNT_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [PM_ADDR_W-1:0] bus_addr,
    input logic                 bus_priv,
    input logic [PM_DATA_W-1:0] bus_rdata,
    input logic                 bus_err,
    input logic                 irq_o,
    input logic                 run,
    input logic                 usr_en_q,
    input logic                 wr_fire,
    input logic [PM_DATA_W-1:0] ien_q,
    input logic [PM_DATA_W-1:0] ovf_q,
    input logic [CNT_W-1:0]     cyc_cnt,
    input logic                 cyc_step
);
    // R1: with global run off and no write, the cycle counter holds
    a_r1_cyc_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_fire) |=> $stable(cyc_cnt));

    // R8: a cycle-counter wrap raises its flag
    a_r8_cyc_wrap_flag: assert property (@(posedge clk) disable iff (rst)
        (cyc_step && (&cyc_cnt) && !wr_fire) |=> ovf_q[PM_CYC_BIT]);

    // R11: blocked access errors and returns zero
    a_r11_blocked: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd || bus_wr) && !bus_priv && !usr_en_q) |-> (bus_err && bus_rdata == '0));

    // R4: control read view
    a_r4_ctrl_view: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == REG_CTRL && !bus_err)
            |-> (bus_rdata[2:1] == 2'b00 && bus_rdata[15:11] == 5'(NUM_CNT)));

    // R9: no enables, no interrupt
    a_r9_irq_masked: assert property (@(posedge clk) disable iff (rst)
        (ien_q == '0) |-> !irq_o);
endmodule

bind perf_mon_unit perf_mon_checker #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_priv (bus_priv),
    .bus_rdata(bus_rdata),
    .bus_err  (bus_err),
    .irq_o    (irq_o),
    .run      (ctrl_q.run),
    .usr_en_q (usr_en_q),
    .wr_fire  (wr_fire),
    .ien_q    (ien_q),
    .ovf_q    (ovf_q),
    .cyc_cnt  (cyc_cnt),
    .cyc_step (cyc_step)
);

// File: tb/perf_mon_unit_bench.sv
module perf_mon_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [255:0] event_in = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_priv = 1'b1;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] rd_val;
    logic        rd_err;
    logic        wr_err;

    always #10 clk = ~clk;

    perf_mon_unit u_perf_mon_unit (
        .clk(clk), .rst(rst), .event_in(event_in),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_priv(bus_priv),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .irq_o(irq_o)
    );

    localparam logic [3:0] A_CTRL = 4'd0, A_SEL = 4'd1, A_TYPE = 4'd2, A_CNT = 4'd3,
                           A_CYC = 4'd4, A_CSET = 4'd5, A_CCLR = 4'd6, A_ISET = 4'd7,
                           A_ICLR = 4'd8, A_OVF = 4'd9, A_SWI = 4'd10, A_USR = 4'd11;

    // {write addr, write data, read addr, expected read, requirement number}
    localparam int NVEC = 14;
    localparam logic [75:0] VEC [NVEC] = '{
        {A_SEL,  32'h0000_0002, A_SEL,  32'h0000_0002, 4'd5},  // R5
        {A_TYPE, 32'h0000_003C, A_TYPE, 32'h0000_003C, 4'd5},  // R5
        {A_SEL,  32'h0000_0004, A_TYPE, 32'h0000_0000, 4'd5},  // R5
        {A_SEL,  32'h0000_0007, A_TYPE, 32'h0000_0000, 4'd5},  // R5 out of range
        {A_TYPE, 32'h0000_0011, A_CNT,  32'h0000_0000, 4'd5},  // R5 dropped
        {A_SEL,  32'h0000_0002, A_TYPE, 32'h0000_003C, 4'd5},  // R5
        {A_CSET, 32'h8000_0005, A_CSET, 32'h8000_0005, 4'd7},  // R7
        {A_CSET, 32'h0000_0040, A_CCLR, 32'h8000_0005, 4'd7},  // R7 unimplemented
        {A_CCLR, 32'h0000_0001, A_CSET, 32'h8000_0004, 4'd7},  // R7
        {A_CCLR, 32'h8000_0004, A_CSET, 32'h0000_0000, 4'd7},  // R7
        {A_ISET, 32'h0000_000A, A_ICLR, 32'h0000_000A, 4'd9},  // R9
        {A_ICLR, 32'h0000_000F, A_ISET, 32'h0000_0000, 4'd9},  // R9
        {A_CTRL, 32'hFFFF_FFFF, A_CTRL, 32'h0000_3009, 4'd4},  // R4
        {A_CTRL, 32'h0000_0000, A_CTRL, 32'h0000_3000, 4'd4}   // R4
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d, input logic p = 1'b1);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_priv = p;
        #1 wr_err = bus_err;
        @(negedge clk);
        bus_wr = 1'b0; bus_priv = 1'b1;
    endtask

    task automatic bus_read(input logic [3:0] a, input logic p = 1'b1);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; bus_priv = p;
        #1 rd_val = bus_rdata; rd_err = bus_err;
        bus_rd = 1'b0; bus_priv = 1'b1;
    endtask

    task automatic summary_and_finish();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary_and_finish();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // Reset state
        bus_read(A_CTRL); check("R4 reset ctrl", rd_val, 32'h0000_3000);
        bus_read(A_CSET); check("R7 reset enables", rd_val, 32'h0);
        bus_read(A_OVF);  check("R8 reset flags", rd_val, 32'h0);
        check("R9 reset irq", {31'b0, irq_o}, 32'h0);

        // Register vector table
        for (int v = 0; v < NVEC; v++) begin
            bus_write(VEC[v][75:72], VEC[v][71:40]);
            bus_read(VEC[v][39:36]);
            check($sformatf("R%0d vector %0d", VEC[v][3:0], v), rd_val, VEC[v][35:4]);
        end

        // R6: event counting on line 5, line 6 ignored
        bus_write(A_SEL, 0); bus_write(A_TYPE, 5); bus_write(A_CSET, 1); bus_write(A_CTRL, 1);
        @(negedge clk); event_in[5] = 1'b1; event_in[6] = 1'b1;
        repeat (10) @(negedge clk);
        event_in[5] = 1'b0; event_in[6] = 1'b0;
        bus_read(A_CNT); check("R6 ten events", rd_val, 32'd10);

        // R1: global run off stops counting
        bus_write(A_CTRL, 0);
        @(negedge clk); event_in[5] = 1'b1;
        repeat (5) @(negedge clk);
        event_in[5] = 1'b0;
        bus_read(A_CNT); check("R1 gated by global run", rd_val, 32'd10);

        // R2: event counter reset
        bus_write(A_CTRL, 32'h2);
        bus_read(A_CNT); check("R2 event clear", rd_val, 32'd0);

        // R6: counter 2 on line 0x3C, counter 0 untouched
        bus_write(A_CSET, 32'h4); bus_write(A_CTRL, 1);
        @(negedge clk); event_in[8'h3C] = 1'b1;
        repeat (3) @(negedge clk);
        event_in[8'h3C] = 1'b0;
        bus_write(A_CTRL, 0);
        bus_write(A_SEL, 2); bus_read(A_CNT); check("R6 counter 2", rd_val, 32'd3);
        bus_write(A_SEL, 0); bus_read(A_CNT); check("R6 counter 0 idle", rd_val, 32'd0);

        // R3: cycle counter, undivided then divided
        bus_write(A_CSET, 32'h8000_0000);
        bus_write(A_CTRL, 32'h5);
        repeat (19) @(posedge clk);
        bus_write(A_CTRL, 32'h0);
        bus_read(A_CYC); check("R3 undivided", rd_val, 32'd20);
        bus_write(A_CTRL, 32'hD);
        repeat (127) @(posedge clk);
        bus_write(A_CTRL, 32'h8);
        bus_read(A_CYC); check("R3 divide by 64", rd_val, 32'd2);
        bus_write(A_CTRL, 32'h4);
        bus_read(A_CYC); check("R2 cycle clear", rd_val, 32'd0);

        // R8 R9 R10: software increment, wrap, interrupt
        bus_write(A_SEL, 1); bus_write(A_TYPE, 0); bus_write(A_CNT, 32'hFFFF_FFFF);
        bus_write(A_CSET, 32'h2); bus_write(A_ISET, 32'h2); bus_write(A_CTRL, 1);
        bus_write(A_SWI, 32'h3);
        bus_read(A_CNT); check("R10 increment wraps", rd_val, 32'd0);
        bus_read(A_OVF); check("R8 flag on wrap", rd_val, 32'h2);
        check("R9 irq raised", {31'b0, irq_o}, 32'h1);
        bus_write(A_SEL, 0); bus_read(A_CNT); check("R10 nonzero code ignores", rd_val, 32'd0);
        bus_write(A_SEL, 1); bus_write(A_SWI, 32'h2);
        bus_read(A_CNT); check("R10 increment", rd_val, 32'd1);
        bus_write(A_OVF, 32'h2);
        bus_read(A_OVF); check("R8 write one clears", rd_val, 32'h0);
        check("R9 irq dropped", {31'b0, irq_o}, 32'h0);
        bus_write(A_ICLR, 32'h2); bus_write(A_CNT, 32'hFFFF_FFFF); bus_write(A_SWI, 32'h2);
        bus_read(A_OVF); check("R8 flag while masked", rd_val, 32'h2);
        check("R9 masked irq", {31'b0, irq_o}, 32'h0);
        bus_write(A_CTRL, 0); bus_write(A_SWI, 32'h2);
        bus_read(A_CNT); check("R10 ignored while stopped", rd_val, 32'd0);

        // R11: privilege
        bus_write(A_SEL, 3, 1'b0);
        check("R11 write error", {31'b0, wr_err}, 32'h1);
        bus_read(A_SEL); check("R11 write dropped", rd_val, 32'd1);
        bus_read(A_SEL, 1'b0);
        check("R11 read zero", rd_val, 32'd0);
        check("R11 read error", {31'b0, rd_err}, 32'h1);
        bus_write(A_USR, 1);
        bus_read(A_SEL, 1'b0);
        check("R11 user read allowed", rd_val, 32'd1);
        check("R11 no error", {31'b0, rd_err}, 32'h0);
        bus_write(A_SEL, 3, 1'b0);
        bus_read(A_SEL); check("R11 user write allowed", rd_val, 32'd3);

        summary_and_finish();
    end
endmodule